// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Arbiter

This block takes up to sixteen pending interrupt requests and picks the one with the highest fixed priority. Bit position sets the priority: bit 0 ranks highest and bit 15 lowest. The arbiter gives the index of the winning source and the 16-bit address of its vector slot. Each source owns a two-byte slot. Source 0 sits at the top of the vector area, and every lower-ranked source takes the next pair of bytes below it.

The CPU supplies a two-bit interrupt mask level. At level 3, every maskable source is held off. The two top-ranked sources, reset and the software trap, always get through. The take strobe tells the CPU to enter the selected handler.

A second path builds a wake request for the low-power controller. Each source carries a constant qualifier that says whether it may end a HALT. The SPI source may do so only when its slave-mode flag is set. The PWM source may do so only when its external-clock flag is set. In ACTIVE-HALT only the reset and time-base sources count. Index, vector, valid, take and wake are all registered, so they follow the inputs one clock later.

Top module: `irq_vector_arbiter`

## Requirements
- R1: While valid_o is 1, vec_addr_o equals 16'hFFFE minus twice sel_idx_o. Source 0 maps to FFFEh and source 15 maps to FFE0h.
- R2: sel_idx_o is the lowest set bit position of req_i, so bit 0 has the highest priority.
- R3: Every output reflects the inputs sampled at the previous rising clock edge, which is exactly one cycle of latency.
- R4: While rst_n is low, the outputs are valid_o=0, take_o=0, wake_o=0, sel_idx_o=0 and vec_addr_o=16'hFFFE. With no request pending they return to the same values.
- R5: When mask_lvl_i is 2'b11, take_o stays 0 for any selected source with index 2 or higher. valid_o, sel_idx_o and vec_addr_o still report that source.
- R6: When source 0 (reset) or source 1 (software trap) is selected, take_o is 1 at every mask level.
- R7: When mask_lvl_i is 0, 1 or 2 and a request is pending, take_o is 1.
- R8: With halt_i=1 and active_halt_i=0, the following sources raise wake_o: 0, 2, 3, 4, 5, 6, 7 and 8. Sources 1 and 10 to 14 do not.
- R9: In HALT, source 9 (SPI) raises wake_o only while spi_slave_i is 1.
- R10: In HALT, source 15 (PWM) raises wake_o only while pwm_ext_clk_i is 1.
- R11: With active_halt_i=1, only sources 0 and 3 raise wake_o. active_halt_i takes precedence over halt_i.
- R12: With halt_i=0 and active_halt_i=0, wake_o is 0. wake_o never depends on mask_lvl_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 16 | Pending requests, bit 0 highest priority |
| mask_lvl_i | input | 2 | CPU interrupt mask level, 3 blocks maskable sources |
| halt_i | input | 1 | Part is in HALT |
| active_halt_i | input | 1 | Part is in ACTIVE-HALT |
| spi_slave_i | input | 1 | SPI is in slave mode, enabling its HALT wake |
| pwm_ext_clk_i | input | 1 | PWM runs on an external clock, enabling its HALT wake |
| sel_idx_o | output | 4 | Index of the selected source |
| vec_addr_o | output | 16 | Vector slot address of the selected source |
| valid_o | output | 1 | A request was pending |
| take_o | output | 1 | The selected request passes the mask |
| wake_o | output | 1 | A pending request may end the current low-power mode |

## Verification
The bench first sends one-hot requests across all sixteen positions. This pins down the index-to-vector map and the wake qualifier of each source on its own. It then sends multi-bit and random patterns. These show whether the selection follows the lowest set bit rather than some other bit, and whether wake sees every pending source rather than only the winner.

Each pattern is repeated at all four mask levels. That separates the two unmaskable sources from the rest and shows the wake path ignores the mask. Sweeps over the low-power modes, including HALT and ACTIVE-HALT asserted together, with both SPI and PWM flag values, isolate the conditional wake sources and the precedence of ACTIVE-HALT.

// File: rtl/irq_arb_pkg.sv
// Package: shared power-mode type for the interrupt vector arbiter.
// Assumes at most one low-power mode is honoured at a time.
package irq_arb_pkg;
    typedef enum logic [1:0] {
        PWR_RUN         = 2'd0,
        PWR_HALT        = 2'd1,
        PWR_ACTIVE_HALT = 2'd2
    } pwr_mode_e;
endpackage

// File: rtl/irq_prio_enc.sv
// Module: fixed-priority encoder. Finds the lowest set bit of the request
// vector. Assumes bit 0 ranks highest. Reports index 0 when nothing is set.
module irq_prio_enc #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the lowest-ranked bit upward so the highest-ranked set bit wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    // Flag whether any request is pending.
    assign any = |req;
endmodule

// File: rtl/irq_wake_qual.sv
// Module: wake-up qualification. Masks the pending requests with a
// per-source wake qualifier chosen by the power mode and ORs the result.
// Assumes the qualifiers are constants fixed at elaboration.
module irq_wake_qual
    import irq_arb_pkg::*;
#(
    parameter int           N          = 16,
    parameter logic [N-1:0] HALT_WAKE  = 16'h83FD,
    parameter logic [N-1:0] AHALT_WAKE = 16'h0009,
    parameter int           SPI_IDX    = 9,
    parameter int           PWM_IDX    = 15
) (
    input  logic [N-1:0] req,
    input  pwr_mode_e    mode,
    input  logic         spi_slave,
    input  logic         pwm_ext_clk,
    output logic         wake
);
    logic [N-1:0] halt_ok;

    // Build the per-source HALT qualifier. Two sources depend on mode flags.
    for (genvar g = 0; g < N; g++) begin : g_halt_q
        if (g == SPI_IDX) begin : g_spi
            assign halt_ok[g] = HALT_WAKE[g] & spi_slave;
        end else if (g == PWM_IDX) begin : g_pwm
            assign halt_ok[g] = HALT_WAKE[g] & pwm_ext_clk;
        end else begin : g_plain
            assign halt_ok[g] = HALT_WAKE[g];
        end
    end

    // Select the qualifier by power mode and reduce to one wake request.
    always_comb begin
        unique case (mode)
            PWR_ACTIVE_HALT: wake = |(req & AHALT_WAKE);
            PWR_HALT:        wake = |(req & halt_ok);
            default:         wake = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_vector_arbiter.sv
// Module: fixed-priority interrupt vector arbiter (top).
// Selects the highest-ranked pending source, maps it to a two-byte vector
// slot that counts down from VEC_TOP, gates entry with the CPU mask level,
// and raises a wake request in low-power modes. All outputs are registered.
// Assumes requests are already synchronous to clk.
module irq_vector_arbiter
    import irq_arb_pkg::*;
#(
    parameter int                  NUM_SRC      = 16,
    parameter int                  VEC_W        = 16,
    parameter logic [VEC_W-1:0]    VEC_TOP      = 16'hFFFE,
    parameter int                  NUM_UNMASKED = 2,
    parameter logic [NUM_SRC-1:0]  HALT_WAKE    = 16'h83FD,
    parameter logic [NUM_SRC-1:0]  AHALT_WAKE   = 16'h0009,
    parameter int                  SPI_IDX      = 9,
    parameter int                  PWM_IDX      = 15,
    localparam int                 IDX_W        = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [1:0]         mask_lvl_i,
    input  logic               halt_i,
    input  logic               active_halt_i,
    input  logic               spi_slave_i,
    input  logic               pwm_ext_clk_i,
    output logic [IDX_W-1:0]   sel_idx_o,
    output logic [VEC_W-1:0]   vec_addr_o,
    output logic               valid_o,
    output logic               take_o,
    output logic               wake_o
);
    localparam logic [IDX_W-1:0] UNMASK_LIM = IDX_W'(NUM_UNMASKED);
    localparam logic [1:0]       MASK_ALL   = 2'b11;

    logic             enc_any;
    logic [IDX_W-1:0] enc_idx;
    logic [VEC_W-1:0] nxt_vec;
    logic             nxt_take;
    logic             nxt_wake;
    pwr_mode_e        mode;

    irq_prio_enc #(
        .N     (NUM_SRC),
        .IDX_W (IDX_W)
    ) u_enc (
        .req (req_i),
        .any (enc_any),
        .idx (enc_idx)
    );

    // Decode the power mode; ACTIVE-HALT takes precedence over HALT.
    always_comb begin
        if (active_halt_i)  mode = PWR_ACTIVE_HALT;
        else if (halt_i)    mode = PWR_HALT;
        else                mode = PWR_RUN;
    end

    irq_wake_qual #(
        .N          (NUM_SRC),
        .HALT_WAKE  (HALT_WAKE),
        .AHALT_WAKE (AHALT_WAKE),
        .SPI_IDX    (SPI_IDX),
        .PWM_IDX    (PWM_IDX)
    ) u_wake (
        .req         (req_i),
        .mode        (mode),
        .spi_slave   (spi_slave_i),
        .pwm_ext_clk (pwm_ext_clk_i),
        .wake        (nxt_wake)
    );

    // Map the selected index to its two-byte vector slot below VEC_TOP.
    assign nxt_vec = VEC_TOP - VEC_W'({enc_idx, 1'b0});

    // Allow entry for unmaskable sources always, others only below level 3.
    assign nxt_take = enc_any & ((enc_idx < UNMASK_LIM) | (mask_lvl_i != MASK_ALL));

    // Register all outputs; synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_idx_o  <= '0;
            vec_addr_o <= VEC_TOP;
            valid_o    <= 1'b0;
            take_o     <= 1'b0;
            wake_o     <= 1'b0;
        end else begin
            sel_idx_o  <= enc_idx;
            vec_addr_o <= nxt_vec;
            valid_o    <= enc_any;
            take_o     <= nxt_take;
            wake_o     <= nxt_wake;
        end
    end
endmodule

// File: rtl/irq_arb_checker.sv
// Module: property checker for the interrupt vector arbiter, bound to the top.
// Assumes the default source numbering (reset 0, trap 1, time base 3).
module irq_arb_checker #(
    parameter int               NUM_SRC = 16,
    parameter int               VEC_W   = 16,
    parameter logic [VEC_W-1:0] VEC_TOP = 16'hFFFE,
    parameter int               IDX_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] req_i,
    input logic [1:0]         mask_lvl_i,
    input logic               halt_i,
    input logic               active_halt_i,
    input logic [IDX_W-1:0]   sel_idx_o,
    input logic [VEC_W-1:0]   vec_addr_o,
    input logic               valid_o,
    input logic               take_o,
    input logic               wake_o
);
    // R1
    vec_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (vec_addr_o == VEC_TOP - VEC_W'({sel_idx_o, 1'b0})));

    // R3
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (valid_o == (|$past(req_i))));

    // R5
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mask_lvl_i) == 2'b11 && take_o) |-> (sel_idx_o < IDX_W'(2)));

    // R5
    take_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> valid_o);

    // R6
    unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(req_i[0]) || $past(req_i[1]))) |-> take_o);

    // R11
    ahalt_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(active_halt_i) && wake_o) |-> ($past(req_i[0]) || $past(req_i[3])));

    // R12
    run_nowake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(halt_i) && !$past(active_halt_i)) |-> !wake_o);
endmodule

bind irq_vector_arbiter irq_arb_checker #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W),
    .VEC_TOP (VEC_TOP),
    .IDX_W   (IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .mask_lvl_i    (mask_lvl_i),
    .halt_i        (halt_i),
    .active_halt_i (active_halt_i),
    .sel_idx_o     (sel_idx_o),
    .vec_addr_o    (vec_addr_o),
    .valid_o       (valid_o),
    .take_o        (take_o),
    .wake_o        (wake_o)
);

// File: tb/irq_vector_arbiter_test.sv
// Bench: drives inputs on the falling edge and compares every output against
// a behavioural reference on the next falling edge.
module irq_vector_arbiter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_i = '0;
    logic [1:0]  mask_lvl_i = '0;
    logic        halt_i = 1'b0;
    logic        active_halt_i = 1'b0;
    logic        spi_slave_i = 1'b0;
    logic        pwm_ext_clk_i = 1'b0;
    logic [3:0]  sel_idx_o;
    logic [15:0] vec_addr_o;
    logic        valid_o;
    logic        take_o;
    logic        wake_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_vector_arbiter uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req_i),
        .mask_lvl_i    (mask_lvl_i),
        .halt_i        (halt_i),
        .active_halt_i (active_halt_i),
        .spi_slave_i   (spi_slave_i),
        .pwm_ext_clk_i (pwm_ext_clk_i),
        .sel_idx_o     (sel_idx_o),
        .vec_addr_o    (vec_addr_o),
        .valid_o       (valid_o),
        .take_o        (take_o),
        .wake_o        (wake_o)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural HALT wake rule for one source.
    function automatic bit halt_can_wake(int s, bit spi, bit pwm);
        case (s)
            0, 2, 3, 4, 5, 6, 7, 8: return 1'b1;
            9:  return spi;
            15: return pwm;
            default: return 1'b0;
        endcase
    endfunction

    // Apply one input set, let one edge pass, then compare with the model.
    task automatic step(string tag, logic [15:0] r, logic [1:0] m, bit h, bit ah, bit spi, bit pwm);
        int  e_idx;
        bit  e_any;
        bit  e_take;
        bit  e_wake;
        req_i = r; mask_lvl_i = m; halt_i = h; active_halt_i = ah;
        spi_slave_i = spi; pwm_ext_clk_i = pwm;
        e_idx = 0; e_any = 1'b0; e_wake = 1'b0;
        for (int i = 0; i < 16; i++) begin
            if (r[i] && !e_any) begin e_idx = i; e_any = 1'b1; end
        end
        e_take = e_any && (e_idx < 2 || m != 2'b11);
        for (int i = 0; i < 16; i++) begin
            if (r[i]) begin
                if (ah) begin
                    if (i == 0 || i == 3) e_wake = 1'b1;
                end else if (h) begin
                    if (halt_can_wake(i, spi, pwm)) e_wake = 1'b1;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(tag, "valid", int'(valid_o), int'(e_any));
        chk(tag, "index", int'(sel_idx_o), e_idx);
        chk(tag, "vector", int'(vec_addr_o), 16'hFFFE - 2 * e_idx);
        chk(tag, "take", int'(take_o), int'(e_take));
        chk(tag, "wake", int'(wake_o), int'(e_wake));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R4: reset state
        chk("R4", "valid", int'(valid_o), 0);
        chk("R4", "take", int'(take_o), 0);
        chk("R4", "wake", int'(wake_o), 0);
        chk("R4", "index", int'(sel_idx_o), 0);
        chk("R4", "vector", int'(vec_addr_o), 16'hFFFE);
        rst_n = 1'b1;

        // R1 R2 R7: one-hot sweep at open mask
        for (int i = 0; i < 16; i++) step("R1", 16'(1) << i, 2'd0, 0, 0, 0, 0);
        // R2: multi-bit patterns
        step("R2", 16'hFFFF, 2'd1, 0, 0, 0, 0);
        step("R2", 16'h8010, 2'd0, 0, 0, 0, 0);
        step("R2", 16'hC000, 2'd2, 0, 0, 0, 0);
        step("R2", 16'h0A00, 2'd0, 0, 0, 0, 0);
        // R3: change every cycle, one-cycle latency
        step("R3", 16'h0004, 2'd0, 0, 0, 0, 0);
        step("R3", 16'h0100, 2'd0, 0, 0, 0, 0);
        // R4: no request after activity
        step("R4", 16'h0000, 2'd0, 0, 0, 0, 0);
        // R5 R6 R7: every mask level on key patterns
        for (int m = 0; m < 4; m++) begin
            step("R5", 16'h0040, 2'(m), 0, 0, 0, 0);
            step("R6", 16'h0001, 2'(m), 0, 0, 0, 0);
            step("R6", 16'h0002, 2'(m), 0, 0, 0, 0);
            step("R7", 16'h8000, 2'(m), 0, 0, 0, 0);
            step("R6", 16'hF003, 2'(m), 0, 0, 0, 0);
        end
        // R8 R9 R10: HALT sweep with all flag combinations
        for (int f = 0; f < 4; f++) begin
            for (int i = 0; i < 16; i++) step("R8", 16'(1) << i, 2'd0, 1, 0, f[0], f[1]);
        end
        step("R9", 16'h0200, 2'd0, 1, 0, 0, 1);
        step("R9", 16'h0200, 2'd0, 1, 0, 1, 0);
        step("R10", 16'h8000, 2'd0, 1, 0, 1, 0);
        step("R10", 16'h8000, 2'd0, 1, 0, 0, 1);
        step("R8", 16'h7C02, 2'd3, 1, 0, 1, 1);
        // R11: ACTIVE-HALT sweep, alone and together with HALT
        for (int i = 0; i < 16; i++) step("R11", 16'(1) << i, 2'd0, 0, 1, 1, 1);
        for (int i = 0; i < 16; i++) step("R11", 16'(1) << i, 2'd0, 1, 1, 1, 1);
        // R12: run mode and mask independence of wake
        step("R12", 16'hFFFF, 2'd0, 0, 0, 1, 1);
        step("R12", 16'h0008, 2'd3, 1, 0, 0, 0);
        step("R12", 16'h0008, 2'd3, 0, 1, 0, 0);
        // Random mix covering all requirements together
        for (int k = 0; k < 300; k++) begin
            logic [31:0] rv;
            rv = $urandom;
            step("R2", rv[15:0], rv[17:16], rv[18], rv[19] & rv[20], rv[21], rv[22]);
        end
        // R4: reset re-entry
        req_i = 16'h0FF0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R4", "valid", int'(valid_o), 0);
        chk("R4", "vector", int'(vec_addr_o), 16'hFFFE);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule